// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This block is the trap controller for a five-stage in-order pipeline. Decode can report an instruction it does not recognise, and execute can report a signed arithmetic overflow. Each report comes with the program counter of the stage that raised it. When one of them is accepted, the unit squashes the faulting instruction and everything younger than it. It suppresses the faulting register write and records a return address and a one-bit reason. It then steers fetch to a single fixed handler entry point. Instructions already in memory and writeback are left alone and finish normally.

A mispredicted branch resolved in execute uses the same squash-and-redirect path, with its own target. The unit also keeps an arming flag. Accepting an exception disarms it, and only an external return strobe re-arms it, so a second fault cannot overwrite the saved state while the handler runs. All squash and redirect outputs are combinational in the detection cycle, so fetch loads the handler address at the next clock edge. The saved address and reason are registers and change at that same edge.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the saved return address reads 0, the reason bit reads 0, the unit is armed, and with no requests no flush or redirect output is high.
- R2: An armed execute-stage overflow raises the fetch, decode and execute flushes and a one-cycle redirect to 0x80000180, all in the cycle the overflow is presented.
- R3: The gated execute write enable is low in every cycle the overflow input is high, armed or not, and otherwise equals the incoming write enable.
- R4: An armed decode-stage undefined opcode, with no overflow and no mispredict in the same cycle, raises the fetch and decode flushes and a redirect to 0x80000180, and leaves the execute flush low.
- R5: At the clock edge after an exception is accepted, the saved return address becomes the faulting stage's PC plus 4. The reason bit becomes 1 for overflow and 0 for undefined opcode.
- R6: When overflow and undefined opcode arrive in the same cycle, the overflow wins. The reason becomes 1, the saved address is the execute PC plus 4, and the decode request is discarded.
- R7: The saved address and reason bit keep their values at every edge where no exception is accepted.
- R8: Accepting an exception clears the armed flag. While disarmed, requests cause no flush of the execute stage, no redirect to the handler and no change to the saved state.
- R9: A return strobe in a cycle with no accepted exception sets the armed flag at the next edge.
- R10: A mispredict raises the fetch and decode flushes and redirects to the supplied branch target without touching the saved state. It takes precedence over a decode-stage exception in the same cycle, but an accepted overflow overrides its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_undef | input | 1 | Decode reports an undefined opcode |
| id_pc | input | 32 | PC of the instruction in decode |
| ex_ovf | input | 1 | Execute reports arithmetic overflow |
| ex_pc | input | 32 | PC of the instruction in execute |
| ex_wr_en | input | 1 | Register write enable of the execute instruction |
| br_mispredict | input | 1 | Branch in execute was mispredicted |
| br_target | input | 32 | Correct branch target |
| ret_strobe | input | 1 | Handler return; re-arms exceptions |
| flush_if | output | 1 | Squash the fetch stage |
| flush_id | output | 1 | Squash the decode stage |
| flush_ex | output | 1 | Squash the execute stage into a bubble |
| redirect | output | 1 | Load next PC from redirect_pc |
| redirect_pc | output | 32 | Redirect target |
| ex_wr_en_out | output | 1 | Gated execute register write enable |
| epc | output | 32 | Saved return address (faulting PC plus 4) |
| cause | output | 1 | Saved reason: 0 undefined opcode, 1 overflow |
| exc_armed | output | 1 | Exceptions currently accepted |

## Verification
The hardest situations to reach are collisions: overflow and undefined opcode in one cycle, a mispredict against a decode fault, and requests that arrive while the unit is disarmed. Random traffic reaches them only now and then. Directed steps therefore force each collision and the disarm, hold and re-arm sequence. A seeded random phase follows, with request densities high enough that every pairing recurs many times against the bench's own model of the arming flag and saved state.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;

  // one-hot (or empty) selection of who owns the squash path this cycle
  typedef struct packed {
    logic from_ex;   // accepted overflow
    logic from_id;   // accepted undefined opcode
    logic from_br;   // mispredict redirect
  } squash_sel_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed,
  input  logic        ex_ovf,
  input  logic        id_undef,
  input  logic        br_mispredict,
  output squash_sel_t sel
);

  logic ex_win, id_win, br_win;

  always_comb begin
    ex_win = armed & ex_ovf;
    // decode fault is younger than both an overflow and a branch in execute
    id_win = armed & id_undef & ~ex_ovf & ~br_mispredict;
    br_win = br_mispredict & ~ex_win;
    sel.from_ex = ex_win;
    sel.from_id = id_win;
    sel.from_br = br_win;
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel.from_ex, sel.from_id, sel.from_br})) else $error("owner"); // R6

  AST_DISARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !(sel.from_ex || sel.from_id)) else $error("disarmed"); // R8

endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] HANDLER_PC = 32'h8000_0180
)(
  input  logic            clk,
  input  logic            rst_n,
  input  squash_sel_t     sel,
  input  logic            ex_ovf,
  input  logic            ex_wr_en,
  input  logic [XLEN-1:0] br_target,
  output logic            flush_if,
  output logic            flush_id,
  output logic            flush_ex,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            ex_wr_en_out
);

  localparam logic [XLEN-1:0] VEC = XLEN'(HANDLER_PC);

  logic trap_now;

  always_comb begin
    trap_now     = sel.from_ex | sel.from_id;
    flush_if     = trap_now | sel.from_br;
    flush_id     = trap_now | sel.from_br;
    flush_ex     = sel.from_ex;
    redirect     = trap_now | sel.from_br;
    redirect_pc  = trap_now ? VEC : br_target;
    ex_wr_en_out = ex_wr_en & ~ex_ovf;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |-> !ex_wr_en_out) else $error("ovf write"); // R3

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    sel.from_ex |-> (redirect && redirect_pc == VEC && flush_ex && flush_id && flush_if)) else $error("vec"); // R2

  AST_ID_KEEPS_EX: assert property (@(posedge clk) disable iff (!rst_n)
    sel.from_id |-> (!flush_ex && flush_id && flush_if)) else $error("id flush"); // R4

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  squash_sel_t     sel,
  input  logic [XLEN-1:0] ex_pc,
  input  logic [XLEN-1:0] id_pc,
  input  logic            ret_strobe,
  output logic [XLEN-1:0] epc,
  output logic            cause,
  output logic            armed
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  function automatic logic [XLEN-1:0] return_addr(input logic [XLEN-1:0] pc);
    return pc + STEP;
  endfunction

  logic   take;
  logic   take_seen_q;
  cause_e cause_q;

  assign take = sel.from_ex | sel.from_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc     <= '0;
      cause_q <= CAUSE_UNDEF;
      armed   <= 1'b1;
    end else begin
      if (sel.from_ex) begin
        epc     <= return_addr(ex_pc);
        cause_q <= CAUSE_OVF;
      end else if (sel.from_id) begin
        epc     <= return_addr(id_pc);
        cause_q <= CAUSE_UNDEF;
      end
      if (take)            armed <= 1'b0;
      else if (ret_strobe) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) take_seen_q <= 1'b0;
    else        take_seen_q <= take;
  end

  assign cause = cause_q;

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(epc) && $stable(cause))) else $error("hold"); // R7

  AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !armed) else $error("disarm"); // R8

  AST_EX_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    sel.from_ex |=> (cause == 1'b1 && epc == $past(ex_pc) + STEP)) else $error("ex rec"); // R5

  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !take) |=> armed) else $error("rearm"); // R9

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_seen_q |-> !take) else $error("pulse"); // R8

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] HANDLER_PC = 32'h8000_0180
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_undef,
  input  logic [XLEN-1:0] id_pc,
  input  logic            ex_ovf,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_wr_en,
  input  logic            br_mispredict,
  input  logic [XLEN-1:0] br_target,
  input  logic            ret_strobe,
  output logic            flush_if,
  output logic            flush_id,
  output logic            flush_ex,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            ex_wr_en_out,
  output logic [XLEN-1:0] epc,
  output logic            cause,
  output logic            exc_armed
);

  squash_sel_t sel;
  logic        armed_w;

  exc_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .armed        (armed_w),
    .ex_ovf       (ex_ovf),
    .id_undef     (id_undef),
    .br_mispredict(br_mispredict),
    .sel          (sel)
  );

  exc_redirect #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_redir (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .ex_ovf      (ex_ovf),
    .ex_wr_en    (ex_wr_en),
    .br_target   (br_target),
    .flush_if    (flush_if),
    .flush_id    (flush_id),
    .flush_ex    (flush_ex),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .ex_wr_en_out(ex_wr_en_out)
  );

  exc_state #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .ex_pc     (ex_pc),
    .id_pc     (id_pc),
    .ret_strobe(ret_strobe),
    .epc       (epc),
    .cause     (cause),
    .armed     (armed_w)
  );

  assign exc_armed = armed_w;

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_mispredict && !ex_ovf) |-> (redirect && redirect_pc == br_target && !flush_ex)) else $error("br"); // R10

endmodule

// File: tb/tb_exc_ctrl_unit.sv
`timescale 1ns/1ps
module tb_exc_ctrl_unit;

  localparam logic [31:0] VEC = 32'h8000_0180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_undef = 0, ex_ovf = 0, ex_wr_en = 0, br_mispredict = 0, ret_strobe = 0;
  logic [31:0] id_pc = 0, ex_pc = 0, br_target = 0;
  logic flush_if, flush_id, flush_ex, redirect, ex_wr_en_out, cause, exc_armed;
  logic [31:0] redirect_pc, epc;

  int total = 0;
  int bad = 0;

  // bench model state
  logic        m_armed = 1'b1;
  logic [31:0] m_epc = '0;
  logic        m_cause = 1'b0;

  always #2.5 clk = ~clk;

  exc_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .id_undef(id_undef), .id_pc(id_pc), .ex_ovf(ex_ovf),
    .ex_pc(ex_pc), .ex_wr_en(ex_wr_en), .br_mispredict(br_mispredict),
    .br_target(br_target), .ret_strobe(ret_strobe), .flush_if(flush_if),
    .flush_id(flush_id), .flush_ex(flush_ex), .redirect(redirect),
    .redirect_pc(redirect_pc), .ex_wr_en_out(ex_wr_en_out), .epc(epc),
    .cause(cause), .exc_armed(exc_armed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ret_of(input logic [31:0] pc);
    return pc + 32'd4;
  endfunction

  // one cycle: drive after the falling edge, check mid-cycle, advance model at the rising edge
  task automatic step(input logic ov, input logic ud, input logic br, input logic rt,
                      input logic we, input logic [31:0] epcv, input logic [31:0] ipcv,
                      input logic [31:0] tgt);
    logic trap_ex, trap_id, br_own;
    @(negedge clk);
    ex_ovf = ov; id_undef = ud; br_mispredict = br; ret_strobe = rt;
    ex_wr_en = we; ex_pc = epcv; id_pc = ipcv; br_target = tgt;
    #1;
    trap_ex = m_armed && ov;
    trap_id = m_armed && ud && !ov && !br;
    br_own  = br && !trap_ex;
    chk("R2 flush_ex", {31'd0, flush_ex}, {31'd0, trap_ex});
    chk("R4 flush_if", {31'd0, flush_if}, {31'd0, trap_ex || trap_id || br_own});
    chk("R4 flush_id", {31'd0, flush_id}, {31'd0, trap_ex || trap_id || br_own});
    chk("R8 redirect", {31'd0, redirect}, {31'd0, trap_ex || trap_id || br_own});
    if (trap_ex || trap_id)  chk("R2 redirect_pc", redirect_pc, VEC);
    else if (br_own)         chk("R10 redirect_pc", redirect_pc, tgt);
    chk("R3 wr gate", {31'd0, ex_wr_en_out}, {31'd0, we && !ov});
    chk("R7 epc", epc, m_epc);
    chk("R7 cause", {31'd0, cause}, {31'd0, m_cause});
    chk("R8 armed", {31'd0, exc_armed}, {31'd0, m_armed});
    @(posedge clk);
    if (trap_ex)      begin m_epc = ret_of(epcv); m_cause = 1'b1; end
    else if (trap_id) begin m_epc = ret_of(ipcv); m_cause = 1'b0; end
    if (trap_ex || trap_id) m_armed = 1'b0;
    else if (rt)            m_armed = 1'b1;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 epc", epc, 32'd0);
    chk("R1 cause", {31'd0, cause}, 32'd0);
    chk("R1 armed", {31'd0, exc_armed}, 32'd1);
    chk("R1 redirect", {31'd0, redirect}, 32'd0);

    // R2 / R5 overflow taken
    step(1, 0, 0, 0, 1, 32'h0000_1000, 32'h0000_1004, 32'h0);
    chk("R5 epc ovf", epc, 32'h0000_1004);
    chk("R5 cause ovf", {31'd0, cause}, 32'd1);
    // R8 held request while disarmed: no redirect, state unchanged
    step(1, 1, 0, 0, 1, 32'h0000_5000, 32'h0000_5004, 32'h0);
    chk("R8 disarmed epc", epc, 32'h0000_1004);
    chk("R8 disarmed armed", {31'd0, exc_armed}, 32'd0);
    // R9 re-arm
    step(0, 0, 0, 1, 0, 32'h0, 32'h0, 32'h0);
    chk("R9 rearmed", {31'd0, exc_armed}, 32'd1);
    // R4 decode fault
    step(0, 1, 0, 0, 1, 32'h0000_1ffc, 32'h0000_2000, 32'h0);
    chk("R5 epc undef", epc, 32'h0000_2004);
    chk("R5 cause undef", {31'd0, cause}, 32'd0);
    step(0, 0, 0, 1, 0, 32'h0, 32'h0, 32'h0);
    // R6 simultaneous
    step(1, 1, 0, 0, 0, 32'h0000_3000, 32'h0000_3004, 32'h0);
    chk("R6 epc", epc, 32'h0000_3004);
    chk("R6 cause", {31'd0, cause}, 32'd1);
    step(0, 0, 0, 1, 0, 32'h0, 32'h0, 32'h0);
    // R10 mispredict beats decode fault
    step(0, 1, 1, 0, 0, 32'h0000_4000, 32'h0000_4004, 32'h0000_8800);
    chk("R10 armed kept", {31'd0, exc_armed}, 32'd1);
    chk("R10 epc kept", epc, 32'h0000_3004);
    // R10 overflow overrides branch target
    step(1, 0, 1, 0, 0, 32'h0000_6000, 32'h0000_6004, 32'h0000_9900);
    chk("R10 ovf over br epc", epc, 32'h0000_6004);
    step(0, 0, 0, 1, 0, 32'h0, 32'h0, 32'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a, b, t;
      a = {$urandom()} & 32'hFFFF_FFFC;
      b = {$urandom()} & 32'hFFFF_FFFC;
      t = {$urandom()} & 32'hFFFF_FFFC;
      step(($urandom() % 6) == 0, ($urandom() % 5) == 0, ($urandom() % 7) == 0,
           ($urandom() % 4) == 0, ($urandom() % 2) == 0, a, b, t);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule